// File: doc/BRIEF.md
# Two-Port Static Memory with Address-Contention Arbitration

This block is a clocked model of a symmetric two-port memory of 2048 words by 8 bits. A left and a right port each have an address, a chip enable, a write select, an output enable, write data and registered read data. Both ports may reach any word in any cycle. When both are enabled on the same address, an arbiter flags the port that lost the contention on its BUSY pin. A write from that port is held off until the flag drops. Reads are never held off.

A mode pin selects between two roles. In master mode the block arbitrates and drives the two BUSY outputs. In slave mode the arbiter's outputs are forced low, and a per-port BUSY input from an external master is used only to suppress writes on that port. The ports are plain synchronous access pins with no valid/ready handshake. BUSY is the only stall signal, and it is the caller's job to keep a write request asserted until BUSY is low. BUSY is combinational from the current cycle's port inputs and the arbiter's registered history. The memory takes a write at the clock edge that closes the cycle in which the write is presented and allowed.

Top module: `dpram_arb`

## Requirements
- R1: While reset is asserted both BUSY outputs are low and read data is zero. After reset, no earlier contention is remembered, so an enable held on through reset counts as newly started in the first cycle after release.
- R2: In master mode a port's BUSY output is high exactly when both chip enables are high, both addresses are equal and that port lost arbitration. It falls in the same cycle that the addresses differ or either enable drops.
- R3: The winner is the port whose enable and address were already unchanged from the previous cycle while the other port's enable or address is new. The loser stays the same for as long as neither port changes its enable or address.
- R4: If both ports start a matching access in the same cycle, the left port wins and the right port's BUSY goes high.
- R5: A write (enable high and write select high) from a port whose effective BUSY is high leaves the memory unchanged.
- R6: A write request that is held while BUSY is high is taken at the clock edge closing the first cycle in which BUSY is low.
- R7: A word written at one edge can be read by the opposite port one edge later. A read of that word presented in the same cycle as the write returns the previous contents.
- R8: Read data is registered. After an edge at which enable and output enable were both high it shows the word at the address presented; otherwise it shows zero.
- R9: A port whose BUSY is high may still read, and it gets the current memory contents.
- R10: In slave mode both BUSY outputs stay low, and each port's BUSY input blocks writes on that port only.
- R11: In slave mode, if both ports write the same address at the same edge, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| master_mode | input | 1 | 1: arbitrate and drive BUSY; 0: BUSY inputs gate writes |
| l_ce | input | 1 | Left chip enable, active high |
| l_we | input | 1 | Left write select (1 write, 0 read) |
| l_oe | input | 1 | Left output enable, active high |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_busy_o | output | 1 | Left lost arbitration (master mode) |
| l_busy_i | input | 1 | Left write inhibit from an external master (slave mode) |
| r_ce | input | 1 | Right chip enable, active high |
| r_we | input | 1 | Right write select (1 write, 0 read) |
| r_oe | input | 1 | Right output enable, active high |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_busy_o | output | 1 | Right lost arbitration (master mode) |
| r_busy_i | input | 1 | Right write inhibit from an external master (slave mode) |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=8. That gives a 16-word store, so each address the bench uses is easy to preload and read back, while the arbiter still compares full-width addresses. The small depth keeps every contention case within a few cycles: older-port wins in both directions, the simultaneous tie, both ports moving together to a new matching word, and release by address change or by enable drop. It also brings the rest within easy reach: blocked writes followed by their completion, same-cycle collisions between a read and a write, and history being cleared by reset while the inputs still match.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  // Which port currently holds a contended word.
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int NPORT = 2;
  localparam int PL    = 0;
  localparam int PR    = 1;
endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          master,
  input  logic [NPORT-1:0]              ce,
  input  logic [NPORT-1:0][ADDR_W-1:0]  addr,
  output logic [NPORT-1:0]              busy
);
  logic [NPORT-1:0]             ce_q;
  logic [NPORT-1:0][ADDR_W-1:0] addr_q;
  logic [NPORT-1:0]             fresh;
  logic                         match;
  owner_e                       owner_q, owner_d;

  // A port's access is new when its enable just rose or its address moved.
  for (genvar p = 0; p < NPORT; p++) begin : g_fresh
    assign fresh[p] = ce[p] && (!ce_q[p] || (addr_q[p] != addr[p]));
  end

  assign match = ce[PL] && ce[PR] && (addr[PL] == addr[PR]);

  always_comb begin
    if (!match) begin
      owner_d = OWN_NONE;
    end else if (!fresh[PL] && !fresh[PR] && (owner_q != OWN_NONE)) begin
      owner_d = owner_q;
    end else if (fresh[PL] && !fresh[PR]) begin
      owner_d = OWN_RIGHT;
    end else begin
      owner_d = OWN_LEFT;
    end
  end

  assign busy[PL] = rst_n && master && (owner_d == OWN_RIGHT);
  assign busy[PR] = rst_n && master && (owner_d == OWN_LEFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q    <= '0;
      addr_q  <= '0;
      owner_q <= OWN_NONE;
    end else begin
      ce_q    <= ce;
      addr_q  <= addr;
      owner_q <= owner_d;
    end
  end

  // R2
  busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|busy) |-> match);

  // R2
  match_flags_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master && match) |-> $countones(busy) == 1);

  // R4
  single_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy));

  // R3
  loser_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master && match && !fresh[PL] && !fresh[PR] && $past(master && match))
      |-> busy == $past(busy));

  // R10
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> busy == '0);
endmodule

// File: rtl/dpram_store.sv
module dpram_store
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORT-1:0]              wr_en,
  input  logic [NPORT-1:0]              rd_en,
  input  logic [NPORT-1:0][ADDR_W-1:0]  addr,
  input  logic [NPORT-1:0][DATA_W-1:0]  wdata,
  output logic [NPORT-1:0][DATA_W-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Right is applied first so that the left port's value lands last.
  always_ff @(posedge clk) begin
    if (wr_en[PR]) mem[addr[PR]] <= wdata[PR];
    if (wr_en[PL]) mem[addr[PL]] <= wdata[PL];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rdata[p] <= '0;
      else if (rd_en[p]) rdata[p] <= mem[addr[p]];
      else               rdata[p] <= '0;
    end

    // R8
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[p] |=> rdata[p] == '0);
  end
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_busy_o,
  input  logic              l_busy_i,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_busy_o,
  input  logic              r_busy_i
);
  logic [NPORT-1:0]             ce, we, oe, busy_in, arb_busy, hold, wr_en, rd_en;
  logic [NPORT-1:0][ADDR_W-1:0] addr;
  logic [NPORT-1:0][DATA_W-1:0] wdata, rdata;

  assign ce      = {r_ce, l_ce};
  assign we      = {r_we, l_we};
  assign oe      = {r_oe, l_oe};
  assign busy_in = {r_busy_i, l_busy_i};
  assign addr    = {r_addr, l_addr};
  assign wdata   = {r_wdata, l_wdata};

  dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .master (master_mode),
    .ce     (ce),
    .addr   (addr),
    .busy   (arb_busy)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_gate
    assign hold[p]  = master_mode ? arb_busy[p] : busy_in[p];
    assign wr_en[p] = ce[p] && we[p] && !hold[p];
    assign rd_en[p] = ce[p] && oe[p];
  end

  dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  assign l_rdata  = rdata[PL];
  assign r_rdata  = rdata[PR];
  assign l_busy_o = arb_busy[PL];
  assign r_busy_o = arb_busy[PR];

  // R5
  l_blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && l_busy_o) |-> !wr_en[PL]);

  // R5
  r_blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && r_busy_o) |-> !wr_en[PR]);

  // R10
  slave_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && (l_busy_i || r_busy_i)) |-> !(wr_en & busy_in));
endmodule

// File: tb/dpram_arb_test.sv
`timescale 1ns/1ps
module dpram_arb_test;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NV = 11;

  // {master, l_ce, l_addr[3:0], r_ce, r_addr[3:0], exp_l_busy, exp_r_busy}
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 1'b1, 4'd3, 1'b0, 4'd0, 1'b0, 1'b0},  // R2 one port alone
    {1'b1, 1'b1, 4'd3, 1'b1, 4'd3, 1'b0, 1'b1},  // R3 right is newcomer
    {1'b1, 1'b1, 4'd3, 1'b1, 4'd3, 1'b0, 1'b1},  // R3 held
    {1'b1, 1'b1, 4'd3, 1'b1, 4'd5, 1'b0, 1'b0},  // R2 address mismatch
    {1'b1, 1'b1, 4'd3, 1'b1, 4'd3, 1'b0, 1'b1},  // R3 right new again
    {1'b1, 1'b0, 4'd3, 1'b1, 4'd3, 1'b0, 1'b0},  // R2 enable dropped
    {1'b1, 1'b1, 4'd3, 1'b1, 4'd3, 1'b1, 1'b0},  // R3 left is newcomer
    {1'b1, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0},  // idle
    {1'b1, 1'b1, 4'd7, 1'b1, 4'd7, 1'b0, 1'b1},  // R4 tie
    {1'b1, 1'b1, 4'd9, 1'b1, 4'd9, 1'b0, 1'b1},  // R4 both move together
    {1'b0, 1'b1, 4'd9, 1'b1, 4'd9, 1'b0, 1'b0}   // R10 slave quiet
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic l_ce = 0, l_we = 0, l_oe = 0, l_busy_i = 0;
  logic r_ce = 0, r_we = 0, r_oe = 0, r_busy_i = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_o, r_busy_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dpram_arb #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_busy_o(l_busy_o), .l_busy_i(l_busy_i),
    .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_busy_o(r_busy_o), .r_busy_i(r_busy_i)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drv_l(input logic ce, input logic we, input logic oe,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_ce = ce; l_we = we; l_oe = oe; l_addr = a; l_wdata = d;
  endtask

  task automatic drv_r(input logic ce, input logic we, input logic oe,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_ce = ce; r_we = we; r_oe = oe; r_addr = a; r_wdata = d;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) step();
    chk("R1 l_busy in reset", {7'd0, l_busy_o}, 8'd0);
    chk("R1 r_busy in reset", {7'd0, r_busy_o}, 8'd0);
    chk("R1 l_rdata in reset", l_rdata, 8'd0);
    chk("R1 r_rdata in reset", r_rdata, 8'd0);
    rst_n = 1'b1;
    step();

    // Arbitration table
    for (int i = 0; i < NV; i++) begin
      master_mode = VEC[i][12];
      drv_l(VEC[i][11], 1'b0, 1'b0, VEC[i][10:7], 8'h00);
      drv_r(VEC[i][6], 1'b0, 1'b0, VEC[i][5:2], 8'h00);
      #1;
      chk($sformatf("R2/R3/R4 vec %0d l_busy", i), {7'd0, l_busy_o}, {7'd0, VEC[i][1]});
      chk($sformatf("R2/R3/R4 vec %0d r_busy", i), {7'd0, r_busy_o}, {7'd0, VEC[i][0]});
      step();
    end

    master_mode = 1'b1;
    drv_l(0, 0, 0, 0, 0); drv_r(0, 0, 0, 0, 0);
    step();

    // R7 port-to-port visibility
    drv_l(1, 1, 0, 4'd2, 8'hA5);
    step();
    drv_l(0, 0, 0, 0, 0); drv_r(1, 0, 1, 4'd2, 0);
    step();
    chk("R7 right sees left write", r_rdata, 8'hA5);
    drv_l(0, 0, 0, 0, 0); drv_r(0, 0, 0, 0, 0);
    step();
    // R7 same-cycle read returns old; R9 busy port reads
    drv_l(1, 1, 0, 4'd2, 8'h5A); drv_r(1, 0, 1, 4'd2, 0);
    #1;
    chk("R4 tie right busy", {7'd0, r_busy_o}, 8'd1);
    step();
    chk("R7 R9 same-cycle read old", r_rdata, 8'hA5);
    drv_l(0, 0, 0, 0, 0);
    step();
    chk("R7 next read new", r_rdata, 8'h5A);

    // R5 / R6 blocked write then completion
    drv_l(0, 0, 0, 0, 0); drv_r(1, 1, 0, 4'd4, 8'h11);
    step();
    drv_r(1, 0, 1, 4'd4, 0); drv_l(1, 1, 0, 4'd4, 8'h3C);
    #1;
    chk("R3 left newcomer busy", {7'd0, l_busy_o}, 8'd1);
    chk("R3 right holder free", {7'd0, r_busy_o}, 8'd0);
    step();
    step();
    chk("R5 blocked write left memory", r_rdata, 8'h11);
    drv_r(0, 0, 0, 0, 0);
    #1;
    chk("R2 release on enable drop", {7'd0, l_busy_o}, 8'd0);
    step();
    drv_r(1, 0, 1, 4'd4, 0);
    #1;
    chk("R3 right now newcomer", {7'd0, r_busy_o}, 8'd1);
    step();
    chk("R6 R9 held write completed", r_rdata, 8'h3C);

    // R8 output gating
    drv_r(0, 0, 0, 0, 0); drv_l(1, 0, 0, 4'd4, 0);
    step();
    chk("R8 oe low gives zero", l_rdata, 8'h00);
    drv_l(1, 0, 1, 4'd4, 0);
    step();
    chk("R8 read valid", l_rdata, 8'h3C);
    drv_l(0, 0, 1, 4'd4, 0);
    step();
    chk("R8 ce low gives zero", l_rdata, 8'h00);

    // R10 slave mode
    drv_l(1, 1, 0, 4'd6, 8'h22);
    step();
    master_mode = 1'b0; l_busy_i = 1'b1;
    drv_l(1, 1, 0, 4'd6, 8'h77);
    #1;
    chk("R10 slave l_busy_o low", {7'd0, l_busy_o}, 8'd0);
    chk("R10 slave r_busy_o low", {7'd0, r_busy_o}, 8'd0);
    step();
    drv_l(1, 0, 1, 4'd6, 0);
    step();
    chk("R10 busy input blocks write", l_rdata, 8'h22);
    l_busy_i = 1'b0; r_busy_i = 1'b1;
    drv_l(1, 1, 0, 4'd6, 8'h77); drv_r(1, 1, 0, 4'd6, 8'h99);
    #1;
    chk("R10 slave no busy on match", {7'd0, r_busy_o}, 8'd0);
    step();
    drv_l(1, 0, 1, 4'd6, 0); drv_r(0, 0, 0, 0, 0);
    step();
    chk("R10 only own port inhibited", l_rdata, 8'h77);
    // R11 simultaneous slave writes
    r_busy_i = 1'b0;
    drv_l(1, 1, 0, 4'd8, 8'h01); drv_r(1, 1, 0, 4'd8, 8'h02);
    step();
    drv_l(0, 0, 0, 0, 0); drv_r(1, 0, 1, 4'd8, 0);
    step();
    chk("R11 left data stored", r_rdata, 8'h01);

    // R1 history cleared by reset
    master_mode = 1'b1;
    drv_l(0, 0, 0, 0, 0); drv_r(1, 0, 0, 4'd3, 0);
    step();
    drv_l(1, 0, 0, 4'd3, 0);
    #1;
    chk("R3 left busy before reset", {7'd0, l_busy_o}, 8'd1);
    rst_n = 1'b0;
    step();
    chk("R1 l_busy low in reset", {7'd0, l_busy_o}, 8'd0);
    chk("R1 r_busy low in reset", {7'd0, r_busy_o}, 8'd0);
    rst_n = 1'b1;
    #1;
    chk("R1 no history left wins", {7'd0, l_busy_o}, 8'd0);
    chk("R1 no history right busy", {7'd0, r_busy_o}, 8'd1);
    step();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule